// File: doc/BRIEF.md
# Window Watchdog Timer

This block supervises software by means of a 7-bit downcounter. Once armed it counts down by one every fixed number of system clocks. Software must reload the counter before the counter's guard bit (bit 6) drops. It must also not reload too early: a reload is legal only once the counter has fallen to or below a programmed window value. Either kind of failure produces a one-cycle reset pulse. After the pulse the block returns every register to its default.

The block can be armed in two ways: by a control write with the arm bit set, or by a level on the hardware-enable input that would come from a non-volatile option setting. Arming is sticky. No write can disarm the watchdog, and dropping the hardware input does not disarm it either. Only the reset pulse it issues itself, or the system reset, returns it to the disarmed state.

The sequencer has three states: `WD_IDLE` (disarmed, counter frozen), `WD_RUN` (armed, counting) and `WD_FIRE` (reset pulse cycle). The transitions are:
- `WD_IDLE` → `WD_RUN` when arming with a value whose guard bit is set.
- `WD_IDLE` → `WD_FIRE` when arming with the guard bit clear.
- `WD_RUN` → `WD_FIRE` on an early reload, a reload with the guard bit clear, or a decrement out of 0x40.
- `WD_FIRE` → `WD_IDLE` always.

Top module: `win_watchdog`

## Requirements
- R1: After system reset the pulse output is low, the counter reads 0x7F, the window register holds 0x7F and the block is disarmed.
- R2: While disarmed the counter does not change. A control write (`wr_sel_i`=0) with bit 7 clear loads bits 6:0 into the counter without arming.
- R3: A control write with bit 7 set, or a high level on `hw_en_i`, arms the block. Its `active_o` output reads 1 from the following cycle.
- R4: While armed, the counter decrements by one every `PRE_DIV` clocks (default 4), counted from the cycle of arming or of the last reload.
- R5: A decrement from 0x40 issues the reset pulse. After loading value V, the pulse starts (V-63)·`PRE_DIV` clocks after the load edge.
- R6: A control write while armed and while the counter is above the window register issues the reset pulse in the next cycle.
- R7: A control write while armed, with the counter at or below the window value and written bit 6 set, loads the counter, restarts the prescale phase and issues no pulse.
- R8: A control write that leaves the block armed with written bit 6 clear issues the reset pulse in the next cycle. This covers arming writes as well as reloads.
- R9: Arming is sticky. A control write with bit 7 clear, or `hw_en_i` falling, leaves the block armed.
- R10: The reset pulse lasts exactly one cycle. In the following cycle the counter is 0x7F, the window is 0x7F and the block is disarmed.
- R11: A window write (`wr_sel_i`=1) stores bits 6:0 at any time except in the pulse cycle. It never causes a pulse by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous system reset |
| hw_en_i | input | 1 | Hardware arm level from option setting |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control/counter, 1 window |
| wr_data_i | input | 8 | Write data; bit 7 arm, bits 6:0 value |
| wdg_rst_o | output | 1 | One-cycle reset pulse |
| cnt_o | output | 7 | Current counter value |
| active_o | output | 1 | Armed flag |

## Verification
Reloads are tried at three counter positions: far above the window, exactly one step above it, and exactly at it. These separate a strict comparison from a non-strict one and from a missing comparison. Timeouts are measured from several load values and from both arming paths, which pins the prescale ratio and the exact 0x40 threshold. Random sequences mix arm value, window, reload delay and reload value, some of the values with bit 6 clear. These show whether the early-reload and guard-bit checks interact correctly with the prescale phase.

// File: rtl/wwdg_pkg.sv
package wwdg_pkg;
    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    localparam logic SEL_CTRL = 1'b0;
    localparam logic SEL_WIN  = 1'b1;
endpackage

// File: rtl/wwdg_prescaler.sv
module wwdg_prescaler #(
    parameter int PRE_DIV = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    generate
        if (PRE_DIV <= 1) begin : g_nodiv
            assign tick_o = run_i;
        end else begin : g_div
            localparam int PW = $clog2(PRE_DIV);
            localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
            logic [PW-1:0] phase_q;

            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    phase_q <= '0;
                end else if (!run_i || clr_i || phase_q == LAST) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            assign tick_o = run_i && (phase_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/wwdg_refresh_check.sv
module wwdg_refresh_check #(
    parameter int CNT_W = 7
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] win_i,
    input  logic [CNT_W-1:0] new_val_i,
    output logic             early_o,
    output logic             guard_lost_o,
    output logic             at_limit_o
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(1) << (CNT_W - 1);

    always_comb begin
        early_o      = cnt_i > win_i;
        guard_lost_o = !new_val_i[CNT_W-1];
        at_limit_o   = cnt_i == LIMIT;
    end
endmodule

// File: rtl/wwdg_seq_fsm.sv
module wwdg_seq_fsm
    import wwdg_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hw_en_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W:0]   wr_data_i,
    input  logic             tick_i,
    input  logic             early_i,
    input  logic             guard_lost_i,
    input  logic             at_limit_i,
    output logic             run_o,
    output logic             fire_o,
    output logic             pre_clr_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] win_o
);
    localparam int GUARD = CNT_W - 1;

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, win_q;
    logic             wr_ctrl, wr_win, arm_req;
    logic [CNT_W-1:0] load_val;

    assign wr_ctrl  = wr_en_i && (wr_sel_i == SEL_CTRL);
    assign wr_win   = wr_en_i && (wr_sel_i == SEL_WIN);
    assign arm_req  = hw_en_i || (wr_ctrl && wr_data_i[CNT_W]);
    assign load_val = wr_ctrl ? wr_data_i[CNT_W-1:0] : cnt_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (arm_req) begin
                    state_d = load_val[GUARD] ? WD_RUN : WD_FIRE;
                end
            end
            WD_RUN: begin
                if (wr_ctrl) begin
                    state_d = (early_i || guard_lost_i) ? WD_FIRE : WD_RUN;
                end else if (tick_i && at_limit_i) begin
                    state_d = WD_FIRE;
                end
            end
            WD_FIRE: state_d = WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and window registers
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '1;
            win_q <= '1;
        end else begin
            unique case (state_q)
                WD_FIRE: begin
                    cnt_q <= '1;
                    win_q <= '1;
                end
                WD_IDLE: begin
                    if (wr_ctrl) cnt_q <= wr_data_i[CNT_W-1:0];
                    if (wr_win)  win_q <= wr_data_i[CNT_W-1:0];
                end
                WD_RUN: begin
                    if (wr_ctrl && state_d == WD_RUN) begin
                        cnt_q <= wr_data_i[CNT_W-1:0];
                    end else if (tick_i) begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                    if (wr_win) win_q <= wr_data_i[CNT_W-1:0];
                end
                default: begin
                    cnt_q <= '1;
                    win_q <= '1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        run_o     = (state_q == WD_RUN);
        fire_o    = (state_q == WD_FIRE);
        pre_clr_o = wr_ctrl;
        cnt_o     = cnt_q;
        win_o     = win_q;
    end
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
    parameter int CNT_W   = 7,
    parameter int PRE_DIV = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hw_en_i,
    input  logic             wr_en_i,
    input  logic             wr_sel_i,
    input  logic [CNT_W:0]   wr_data_i,
    output logic             wdg_rst_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o
);
    logic             tick, run, fire, pre_clr;
    logic             early, guard_lost, at_limit;
    logic [CNT_W-1:0] cnt_q, win_q;

    wwdg_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (run),
        .clr_i  (pre_clr),
        .tick_o (tick)
    );

    wwdg_refresh_check #(.CNT_W(CNT_W)) u_chkval (
        .cnt_i        (cnt_q),
        .win_i        (win_q),
        .new_val_i    (wr_data_i[CNT_W-1:0]),
        .early_o      (early),
        .guard_lost_o (guard_lost),
        .at_limit_o   (at_limit)
    );

    wwdg_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hw_en_i      (hw_en_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .tick_i       (tick),
        .early_i      (early),
        .guard_lost_i (guard_lost),
        .at_limit_i   (at_limit),
        .run_o        (run),
        .fire_o       (fire),
        .pre_clr_o    (pre_clr),
        .cnt_o        (cnt_q),
        .win_o        (win_q)
    );

    assign wdg_rst_o = fire;
    assign cnt_o     = cnt_q;
    assign active_o  = run;
endmodule

// File: rtl/wwdg_checker.sv
module wwdg_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_en_i,
    input logic             wr_sel_i,
    input logic [CNT_W:0]   wr_data_i,
    input logic             wdg_rst_o,
    input logic [CNT_W-1:0] cnt_o,
    input logic             active_o,
    input logic [CNT_W-1:0] win_val
);
    logic wr_ctrl;
    assign wr_ctrl = wr_en_i && !wr_sel_i;

    assert_idle_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_o && !wdg_rst_o && !wr_ctrl) |=> $stable(cnt_o));

    assert_step_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && !wr_ctrl) |=>
            (wdg_rst_o || cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1));

    assert_early_reload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && wr_ctrl && cnt_o > win_val) |=> wdg_rst_o);

    assert_good_reload_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && wr_ctrl && cnt_o <= win_val && wr_data_i[CNT_W-1]) |=>
            (active_o && cnt_o == $past(wr_data_i[CNT_W-1:0])));

    assert_guard_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && wr_ctrl && !wr_data_i[CNT_W-1]) |=> wdg_rst_o);

    assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        active_o |=> (active_o || wdg_rst_o));

    assert_pulse_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wdg_rst_o |=> (!wdg_rst_o && !active_o && cnt_o == '1 && win_val == '1));
endmodule

bind win_watchdog wwdg_checker #(.CNT_W(CNT_W)) u_wwdg_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .wdg_rst_o (wdg_rst_o),
    .cnt_o     (cnt_o),
    .active_o  (active_o),
    .win_val   (win_q)
);

// File: tb/win_watchdog_tb_top.sv
module win_watchdog_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hw_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       wdg_rst;
    logic [6:0] cnt;
    logic       active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    win_watchdog #(.CNT_W(7), .PRE_DIV(DIV)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .hw_en_i   (hw_en),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .wdg_rst_o (wdg_rst),
        .cnt_o     (cnt),
        .active_o  (active)
    );

    function automatic int exp_timeout(input int v);
        return (v - 63) * DIV;
    endfunction

    function automatic int cnt_after(input int v, input int edges);
        return v - edges / DIV;
    endfunction

    function automatic bit exp_fire(input int cnt_at, input int win, input int val);
        return (cnt_at > win) || (val < 64);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; hw_en = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // drive at a falling edge, captured at the next rising edge, return at the falling edge after it
    task automatic wr(input logic sel, input logic [7:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // count rising edges until the pulse is seen; returns count
    task automatic wait_fire(output int n);
        n = 0;
        while (!wdg_rst && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    int n;
    initial begin
        do_reset();
        // R1 reset state
        chk(wdg_rst == 1'b0, "R1", "pulse after reset", wdg_rst, 0);
        chk(cnt == 7'h7F, "R1", "counter after reset", cnt, 'h7F);
        chk(active == 1'b0, "R1", "armed after reset", active, 0);

        // R2 frozen while disarmed, load without arming
        repeat (40) @(negedge clk);
        chk(cnt == 7'h7F && !wdg_rst, "R2", "idle counter", cnt, 'h7F);
        wr(1'b0, 8'h55);
        repeat (20) @(negedge clk);
        chk(cnt == 7'h55 && !active, "R2", "load without arm", cnt, 'h55);

        // R3 R4 R5 software arm and timeout
        wr(1'b0, 8'hC5);
        chk(active == 1'b1, "R3", "armed by write", active, 1);
        repeat (9) @(negedge clk);
        chk(cnt == 7'(cnt_after('h45, 9)), "R4", "decrement rate", cnt, cnt_after('h45, 9));
        wait_fire(n);
        chk(n + 9 == exp_timeout('h45), "R5", "timeout edges", n + 9, exp_timeout('h45));
        // R10 one cycle, defaults after
        @(negedge clk);
        chk(!wdg_rst, "R10", "pulse width", wdg_rst, 0);
        chk(cnt == 7'h7F && !active, "R10", "defaults after pulse", cnt, 'h7F);

        // R9 sticky under a write with arm bit clear
        wr(1'b0, 8'hD0);
        repeat (5) @(negedge clk);
        wr(1'b0, 8'h48);
        chk(active == 1'b1, "R9", "still armed after arm=0 write", active, 1);
        wait_fire(n);
        chk(n == exp_timeout('h48), "R7", "timeout after reload", n, exp_timeout('h48));
        @(negedge clk);

        // R3 R9 hardware arm, then released
        hw_en = 1'b1;
        @(negedge clk);
        hw_en = 1'b0;
        chk(active == 1'b1, "R3", "armed by hw level", active, 1);
        repeat (30) @(negedge clk);
        chk(active == 1'b1, "R9", "armed after hw release", active, 1);
        wait_fire(n);
        chk(n + 30 == exp_timeout('h7F), "R5", "hw timeout", n + 30, exp_timeout('h7F));
        @(negedge clk);

        // R6 early reload, R11 window write when idle
        wr(1'b1, 8'h50);
        chk(!wdg_rst, "R11", "window write alone", wdg_rst, 0);
        wr(1'b0, 8'hFF);
        wr(1'b0, 8'h7F);
        chk(wdg_rst == 1'b1, "R6", "early reload", wdg_rst, 1);
        @(negedge clk);
        // R10 window back to default: same sequence now legal
        wr(1'b0, 8'hFF);
        wr(1'b0, 8'h7F);
        chk(!wdg_rst && active, "R10", "window default after pulse", wdg_rst, 0);
        do_reset();

        // R6 one step above window
        wr(1'b1, 8'h50);
        wr(1'b0, 8'hD2);
        repeat (4) @(negedge clk);
        wr(1'b0, 8'h66);
        chk(wdg_rst == 1'b1, "R6", "reload one above window", wdg_rst, 1);
        do_reset();
        // R7 exactly at window
        wr(1'b1, 8'h50);
        wr(1'b0, 8'hD2);
        repeat (8) @(negedge clk);
        wr(1'b0, 8'h66);
        chk(!wdg_rst && cnt == 7'h66 && active, "R7", "reload at window", cnt, 'h66);
        do_reset();

        // R8 guard bit clear: arming and reloading
        wr(1'b0, 8'hBF);
        chk(wdg_rst == 1'b1, "R8", "arm with guard clear", wdg_rst, 1);
        do_reset();
        wr(1'b0, 8'hFF);
        wr(1'b0, 8'h3F);
        chk(wdg_rst == 1'b1, "R8", "reload with guard clear", wdg_rst, 1);
        do_reset();

        // R11 window write while armed has no immediate effect but is used
        wr(1'b0, 8'hF0);
        wr(1'b1, 8'h40);
        chk(!wdg_rst && active, "R11", "window write while armed", wdg_rst, 0);
        wr(1'b0, 8'h70);
        chk(wdg_rst == 1'b1, "R11", "new window applied", wdg_rst, 1);
        do_reset();

        // random sequences
        void'($urandom(32'd4242));
        for (int it = 0; it < 40; it++) begin
            int v, w, win, val, cat;
            bit ef;
            v   = 64 + int'($urandom_range(0, 63));
            win = 64 + int'($urandom_range(0, 63));
            w   = int'($urandom_range(0, exp_timeout(v) - 1));
            val = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 63))
                                              : 64 + int'($urandom_range(0, 63));
            wr(1'b1, 8'(win));
            wr(1'b0, 8'(128 + v));
            repeat (w) @(negedge clk);
            cat = cnt_after(v, w);
            chk(cnt == 7'(cat), "R4", "random counter", cnt, cat);
            wr(1'b0, 8'(val));
            ef = exp_fire(cat, win, val);
            chk(wdg_rst == ef, ef && val < 64 ? "R8" : "R6", "random reload", wdg_rst, ef);
            do_reset();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule